// File: doc/BRIEF.md
# Flash Bus Write Cycle Qualifier

This block sits between the control pins of a parallel flash-style bus and the command register behind them. It samples active-low chip enable, write enable and output enable with a fast clock and decides which host write cycles are genuine. A write cycle only counts if its qualifying condition holds for a set number of consecutive clock samples. Shorter pulses are treated as noise. When the cycle ends on the rising edge of write enable, the block issues a one-clock `write_strobe` that the command register uses to latch address and data.

Protection is layered on top of the filter. A digital supply-good flag from an external comparator blocks every write while it is low and drives `force_read_mode` so the controller returns to read mode. After reset, and again after every supply recovery, writes are locked out until write enable has been seen high at least once. Because of this, a bus whose strobes are already asserted at power-up cannot produce a command.

Top module: `wr_cycle_gate`

## Requirements
- R1: While `rst` is high, `write_strobe` is 0 and `force_read_mode` is 1.
- R2: A write cycle qualifies only while `ce_n`=0, `we_n`=0 and `oe_n`=1. A write-enable pulse made with `ce_n`=1 or with `oe_n`=0 produces no strobe.
- R3: A qualifying condition lasting fewer than `FILT_SAMPLES` clock samples produces no strobe. One lasting `FILT_SAMPLES` samples or more produces one strobe.
- R4: While `vcc_ok`=0, no strobe is issued. `force_read_mode` rises within `SYNC_STAGES`+1 clocks of `vcc_ok` falling and clears within `SYNC_STAGES`+1 clocks of it rising.
- R5: An accepted write pulse gives exactly one `write_strobe`, one clock wide, within `SYNC_STAGES`+2 clocks of `we_n` rising.
- R6: If `ce_n`=0, `we_n`=0 and `oe_n`=1 are already present when reset is released, the first `we_n` rising edge produces no strobe. The next full write pulse is accepted.
- R7: After `vcc_ok` recovers, a `we_n` rising edge produces no strobe unless `we_n` was seen high after the recovery.
- R8: An armed cycle is dropped if `ce_n` goes high or `oe_n` goes low before `we_n` rises. The rising edge that follows produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Asynchronous active-high reset (power-up) |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| vcc_ok | input | 1 | Supply-good flag from external comparator |
| write_strobe | output | 1 | One-clock pulse marking an accepted write |
| force_read_mode | output | 1 | High while the command logic must sit in read mode |

## Verification
The filter counter, the arming flag and the lockout flag can only be seen at the ports through `write_strobe`. A stuck or early arming flag shows up as a strobe for a pulse that is too short or inhibited. A lockout flag that sets too soon shows up as a strobe on the first rising edge after reset or after supply recovery. Either error is visible within `SYNC_STAGES`+2 clocks of that `we_n` rising edge. A wrong supply state shows on `force_read_mode` within `SYNC_STAGES`+1 clocks.

// File: rtl/wq_pkg.sv
package wq_pkg;
   typedef struct packed {
      logic ce_n;
      logic we_n;
      logic oe_n;
      logic vcc_ok;
   } wq_pins_t;

   localparam int PIN_W = $bits(wq_pins_t);
   // Reset image: strobes read as "asserted", supply as "bad", so nothing
   // from the reset value itself can unlock or arm the gate.
   localparam wq_pins_t PIN_RST = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b0, vcc_ok: 1'b0};
endpackage

// File: rtl/wq_sync.sv
module wq_sync #(
   parameter int              W      = 4,
   parameter int              STAGES = 2,
   parameter logic [W-1:0]    RSTV   = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("wq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or posedge rst) begin
         if (rst)         chain[s] <= RSTV;
         else if (s == 0) chain[s] <= d;
         else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wq_glitch_filter.sv
module wq_glitch_filter #(
   parameter int N = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic qual,
   output logic pass
);
   if (N < 1) begin : g_bad
      $error("wq_glitch_filter: N must be at least 1");
   end

   if (N == 1) begin : g_bypass
      assign pass = qual;
   end else begin : g_count
      localparam int CW = $clog2(N);
      localparam logic [CW-1:0] LAST = CW'(N-1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or posedge rst) begin
         if (rst)           cnt <= '0;
         else if (!qual)    cnt <= '0;
         else if (cnt != LAST) cnt <= cnt + 1'b1;
      end

      assign pass = qual && (cnt == LAST);

      // R3: pass only after N-1 earlier qualifying samples
      assert_filter_hist_R3: assert property (@(posedge clk) disable iff (rst)
         pass |-> $past(qual));
   end
endmodule

// File: rtl/wq_lockout.sv
module wq_lockout (
   input  logic clk,
   input  logic rst,
   input  logic pass,
   input  logic ce_s,
   input  logic we_s,
   input  logic oe_s,
   input  logic vcc_s,
   output logic write_strobe,
   output logic force_read_mode
);
   logic unlocked, armed, we_prev, we_rise, inhibit;

   assign we_rise = we_s && !we_prev;
   assign inhibit = ce_s || !oe_s || !vcc_s || !unlocked;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         unlocked        <= 1'b0;
         armed           <= 1'b0;
         we_prev         <= 1'b0;
         write_strobe    <= 1'b0;
         force_read_mode <= 1'b1;
      end else begin
         we_prev         <= we_s;
         force_read_mode <= !vcc_s;
         if (!vcc_s)    unlocked <= 1'b0;
         else if (we_s) unlocked <= 1'b1;
         write_strobe    <= armed && we_rise && !inhibit;
         if (inhibit || we_rise) armed <= 1'b0;
         else if (pass)          armed <= 1'b1;
      end
   end

   assert_strobe_width_R5: assert property (@(posedge clk) disable iff (rst)
      write_strobe |=> !write_strobe);
   assert_strobe_supply_R4: assert property (@(posedge clk) disable iff (rst)
      write_strobe |-> $past(vcc_s));
   assert_read_mode_R4: assert property (@(posedge clk) disable iff (rst)
      !vcc_s |=> force_read_mode);
   assert_strobe_unlock_R6: assert property (@(posedge clk) disable iff (rst)
      write_strobe |-> $past(unlocked));
   assert_arm_qual_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(armed) |-> $past(!ce_s && !we_s && oe_s));
   assert_cancel_R8: assert property (@(posedge clk) disable iff (rst)
      write_strobe |-> $past(!ce_s && oe_s));
endmodule

// File: rtl/wr_cycle_gate.sv
module wr_cycle_gate #(
   parameter int SYNC_STAGES  = 2,
   parameter int FILT_SAMPLES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ce_n,
   input  logic we_n,
   input  logic oe_n,
   input  logic vcc_ok,
   output logic write_strobe,
   output logic force_read_mode
);
   import wq_pkg::*;

   wq_pins_t raw, syn;
   logic     qual, pass;

   assign raw = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n, vcc_ok: vcc_ok};

   wq_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RSTV(PIN_RST)) sync_i (
      .clk(clk), .rst(rst), .d(raw), .q(syn));

   assign qual = !syn.ce_n && !syn.we_n && syn.oe_n && syn.vcc_ok;

   wq_glitch_filter #(.N(FILT_SAMPLES)) filt_i (
      .clk(clk), .rst(rst), .qual(qual), .pass(pass));

   wq_lockout lock_i (
      .clk(clk), .rst(rst), .pass(pass),
      .ce_s(syn.ce_n), .we_s(syn.we_n), .oe_s(syn.oe_n), .vcc_s(syn.vcc_ok),
      .write_strobe(write_strobe), .force_read_mode(force_read_mode));

   assert_reset_R1: assert property (@(posedge clk)
      rst |=> (!write_strobe && force_read_mode));
endmodule

// File: tb/wr_cycle_gate_tb_top.sv
`timescale 1ns/100ps
module wr_cycle_gate_tb_top;
   logic clk = 1'b0, rst = 1'b1;
   logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vcc_ok = 1'b1;
   logic write_strobe, force_read_mode;
   int   checks = 0, errors = 0, strobes = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   wr_cycle_gate #(.SYNC_STAGES(2), .FILT_SAMPLES(2)) dut_i (
      .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .vcc_ok(vcc_ok), .write_strobe(write_strobe),
      .force_read_mode(force_read_mode));

   always @(negedge clk) if (write_strobe) strobes++;

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   // one write pulse: ce/oe levels, we low length in clocks, returns strobe count
   task automatic pulse(input logic ce, input logic oe, input int len, output int got);
      ce_n = ce; oe_n = oe; cyc(3);
      strobes = 0;
      we_n = 1'b0; cyc(len);
      we_n = 1'b1; cyc(8);
      got = strobes;
      ce_n = 1'b1; oe_n = 1'b1; cyc(3);
   endtask

   // vector: ce_n, oe_n, we-low clocks, expected strobes
   typedef struct packed { logic ce; logic oe; logic [7:0] len; logic [1:0] exp; } vec_t;
   localparam vec_t VECS [8] = '{
      '{1'b0, 1'b1, 8'd6, 2'd1},   // R2 valid cycle
      '{1'b1, 1'b1, 8'd6, 2'd0},   // R2 chip enable high
      '{1'b0, 1'b0, 8'd6, 2'd0},   // R2 output enable low
      '{1'b0, 1'b1, 8'd1, 2'd0},   // R3 one-sample glitch
      '{1'b0, 1'b1, 8'd2, 2'd1},   // R3 exactly the filter length
      '{1'b0, 1'b1, 8'd3, 2'd1},   // R3 above filter length
      '{1'b0, 1'b1, 8'd40, 2'd1},  // R5 long pulse, single strobe
      '{1'b1, 1'b0, 8'd6, 2'd0}    // R2 both inhibits
   };

   initial begin
      int got;
      cyc(1);
      check("R1 strobe in reset", int'(write_strobe), 0);
      check("R1 read mode in reset", int'(force_read_mode), 1);
      cyc(2); rst = 1'b0; cyc(6);
      check("R4 read mode clears with supply good", int'(force_read_mode), 0);

      foreach (VECS[i]) begin
         pulse(VECS[i].ce, VECS[i].oe, int'(VECS[i].len), got);
         check($sformatf("R2/R3/R5 vector %0d", i), got, int'(VECS[i].exp));
      end

      // R8: armed, then chip enable released before we rises
      ce_n = 1'b0; cyc(3); strobes = 0;
      we_n = 1'b0; cyc(6); ce_n = 1'b1; cyc(2); we_n = 1'b1; cyc(8);
      check("R8 ce released before we rise", strobes, 0);
      oe_n = 1'b1; ce_n = 1'b0; cyc(3); strobes = 0;
      we_n = 1'b0; cyc(6); oe_n = 1'b0; cyc(2); we_n = 1'b1; cyc(8);
      check("R8 oe asserted before we rise", strobes, 0);
      ce_n = 1'b1; oe_n = 1'b1; cyc(3);

      // R4: supply low blocks writes and forces read mode
      vcc_ok = 1'b0; cyc(3);
      check("R4 read mode on supply loss", int'(force_read_mode), 1);
      pulse(1'b0, 1'b1, 6, got);
      check("R4 write during supply loss", got, 0);
      vcc_ok = 1'b1; cyc(3);
      check("R4 read mode released", int'(force_read_mode), 0);
      pulse(1'b0, 1'b1, 6, got);
      check("R4 write after recovery", got, 1);

      // R7: supply recovers while we is held low
      ce_n = 1'b0; cyc(2); we_n = 1'b0; cyc(4);
      vcc_ok = 1'b0; cyc(5); vcc_ok = 1'b1; cyc(8);
      strobes = 0; we_n = 1'b1; cyc(8);
      check("R7 first rise after recovery", strobes, 0);
      ce_n = 1'b1; cyc(3);
      pulse(1'b0, 1'b1, 6, got);
      check("R7 next pulse accepted", got, 1);

      // R6: strobes already asserted at power-up
      rst = 1'b1; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; cyc(3);
      rst = 1'b0; cyc(10); strobes = 0;
      we_n = 1'b1; cyc(8);
      check("R6 power-up rise ignored", strobes, 0);
      ce_n = 1'b1; cyc(3);
      pulse(1'b0, 1'b1, 6, got);
      check("R6 following pulse accepted", got, 1);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            cyc(20000);
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule